// File: doc/BRIEF.md
# Register Latency Scoreboard for Bundle Issue

This block keeps, for every entry of a register file, the number of cycles left before a value written to that entry can be read. Writers report a register index and a cycle count during a bundle. The block raises that register's pending latency to at least that count. Writes marked as loads also produce a request toward the cache model, which starts after the writing instruction's last cycle. A second update path adds post-processing cycles. If a load is still outstanding on the target, those cycles wait in a deferred counter until the load completes. Otherwise they are added straight onto the pending latency.

When a bundle issues, the pending latencies are folded into per-register busy counters, which then count down by one every clock. A read-check path takes the source operands of the next bundle and returns, combinationally, the number of stall cycles needed before issue: the largest busy count among the named sources. Operands may be single registers or pairs covering n and n+1. The pair never wraps past the last entry.

Top module: `lat_scoreboard`

## Requirements
- R1: A latency write never lowers a register's pending latency; within a bundle the pending value becomes the larger of its current value and the requested count.
- R2: An operand whose valid flag is low (write, post-processing, completion or source) causes no update and contributes nothing to the stall.
- R3: A write with the pair flag set applies to index n and to n+1; for n equal to the last index only n is touched and index 0 is unaffected.
- R4: A write with the load flag set produces, on the next clock, `ld_req_vld` high with the write's index, its class bit (0 integer, 1 floating) and a start delay equal to the write's cycle count; every other cycle `ld_req_vld` is low.
- R5: A post-processing update on a register with no outstanding load adds its cycles to the pending latency, after any same-cycle max write, saturating at the all-ones counter value.
- R6: For a paired post-processing update, the outstanding-load test is true if either n or n+1 (n+1 only when n is below the last index) has a load outstanding, and both registers of the pair take the addition on the same path.
- R7: When a register's load completes, its deferred counter is added to its pending latency and the deferred counter returns to zero.
- R8: On an issue clock each busy counter becomes the larger of its decremented value and the pending latency including that clock's updates, and all pending latencies return to zero.
- R9: Without issue, every busy counter falls by one per clock and holds at zero.
- R10: `stall` equals the largest busy count over all valid sources, a paired source also reading n+1 when n is below the last index.
- R11: After reset all busy, pending and deferred counters are zero, `stall` is zero and `ld_req_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_vld | input | 1 | Latency write valid |
| wr_idx | input | IDXW | Latency write register index |
| wr_dbl | input | 1 | Latency write covers a register pair |
| wr_load | input | 1 | Latency write is a load |
| wr_cls | input | 1 | Register class for the load request (0 integer, 1 floating) |
| wr_cyc | input | CW | Requested latency in cycles |
| pp_vld | input | 1 | Post-processing update valid |
| pp_idx | input | IDXW | Post-processing register index |
| pp_dbl | input | 1 | Post-processing covers a register pair |
| pp_cyc | input | CW | Post-processing cycles to add |
| ld_pend | input | NREGS | Per-register outstanding-load flags from the cache model |
| ld_done_vld | input | 1 | Load completion valid |
| ld_done_idx | input | IDXW | Register whose load completed |
| issue | input | 1 | The current bundle issues on this clock |
| src_vld | input | NSRC | Source operand valid flags |
| src_idx | input | NSRC*IDXW | Source register indices, source s in bits s*IDXW upward |
| src_dbl | input | NSRC | Source operand is a register pair |
| stall | output | CW | Cycles to wait before the checked bundle may issue |
| ld_req_vld | output | 1 | Cache-load request valid |
| ld_req_idx | output | IDXW | Register index of the load request |
| ld_req_cls | output | 1 | Register class of the load request |
| ld_req_delay | output | CW | Cycles before the load request starts |

## Verification
The bench builds the block with its defaults: 64 registers, 8-bit counters and three sources. With 64 entries, pair operands at the last index can be tried, so the no-wrap rule for writes, post-processing and stall checks is covered. With 8-bit counters, two additions of 200 reach the saturation point at 255. Three sources let the stall maximum be checked with the largest value in different slots and with a pair operand taking the maximum from its upper register.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;
  localparam int unsigned DEF_NREGS = 64;
  localparam int unsigned DEF_CW    = 8;
  localparam int unsigned DEF_NSRC  = 3;

  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FLT = 1'b1
  } reg_cls_e;
endpackage

// File: rtl/lat_sb_lane.sv
module lat_sb_lane #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_cyc,
  input  logic          pp_hit,
  input  logic          pp_defer,
  input  logic [CW-1:0] pp_cyc,
  input  logic          done_hit,
  input  logic          issue,
  output logic [CW-1:0] busy,
  output logic [CW-1:0] lat
);
  logic [CW-1:0] busy_q, busy_d;
  logic [CW-1:0] lat_q, lat_d;
  logic [CW-1:0] pt_q, pt_d;
  logic [CW-1:0] lat_t, dec_t;
  logic          busy_en, lat_en, pt_en;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CW] ? {CW{1'b1}} : s[CW-1:0];
  endfunction

  always_comb begin
    lat_t = lat_q;
    if (wr_hit && (wr_cyc > lat_t)) lat_t = wr_cyc;
    if (pp_hit && !pp_defer)        lat_t = sat_add(lat_t, pp_cyc);
    pt_d = pt_q;
    if (done_hit) begin
      lat_t = sat_add(lat_t, pt_q);
      pt_d  = '0;
    end
    if (pp_hit && pp_defer) pt_d = sat_add(pt_d, pp_cyc);
    dec_t = (busy_q == '0) ? '0 : busy_q - CW'(1);
    if (issue) begin
      busy_d = (lat_t > dec_t) ? lat_t : dec_t;
      lat_d  = '0;
    end else begin
      busy_d = dec_t;
      lat_d  = lat_t;
    end
    busy_en = issue || (busy_q != '0);
    lat_en  = issue || wr_hit || pp_hit || done_hit;
    pt_en   = pp_hit || done_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      lat_q  <= '0;
      pt_q   <= '0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (lat_en)  lat_q  <= lat_d;
      if (pt_en)   pt_q   <= pt_d;
    end
  end

  assign busy = busy_q;
  assign lat  = lat_q;
endmodule

// File: rtl/lat_sb_stall_max.sv
module lat_sb_stall_max #(
  parameter int unsigned NREGS = 64,
  parameter int unsigned CW    = 8,
  parameter int unsigned NSRC  = 3,
  parameter int unsigned IDXW  = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][CW-1:0] busy_all,
  input  logic [NSRC-1:0]          src_vld,
  input  logic [NSRC*IDXW-1:0]     src_idx,
  input  logic [NSRC-1:0]          src_dbl,
  output logic [CW-1:0]            stall
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NREGS - 1);

  always_comb begin
    stall = '0;
    for (int s = 0; s < NSRC; s++) begin
      logic [IDXW-1:0] a;
      a = src_idx[s*IDXW +: IDXW];
      if (src_vld[s]) begin
        if (busy_all[a] > stall) stall = busy_all[a];
        if (src_dbl[s] && (a != LAST) && (busy_all[a + IDXW'(1)] > stall))
          stall = busy_all[a + IDXW'(1)];
      end
    end
  end
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int unsigned NREGS = DEF_NREGS,
  parameter int unsigned CW    = DEF_CW,
  parameter int unsigned NSRC  = DEF_NSRC,
  parameter int unsigned IDXW  = $clog2(NREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_vld,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic                 wr_dbl,
  input  logic                 wr_load,
  input  logic                 wr_cls,
  input  logic [CW-1:0]        wr_cyc,
  input  logic                 pp_vld,
  input  logic [IDXW-1:0]      pp_idx,
  input  logic                 pp_dbl,
  input  logic [CW-1:0]        pp_cyc,
  input  logic [NREGS-1:0]     ld_pend,
  input  logic                 ld_done_vld,
  input  logic [IDXW-1:0]      ld_done_idx,
  input  logic                 issue,
  input  logic [NSRC-1:0]      src_vld,
  input  logic [NSRC*IDXW-1:0] src_idx,
  input  logic [NSRC-1:0]      src_dbl,
  output logic [CW-1:0]        stall,
  output logic                 ld_req_vld,
  output logic [IDXW-1:0]      ld_req_idx,
  output logic                 ld_req_cls,
  output logic [CW-1:0]        ld_req_delay
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NREGS - 1);

  logic [NREGS-1:0][CW-1:0] busy_all;
  logic [NREGS-1:0][CW-1:0] lat_all;
  logic                     pp_defer;

  // outstanding-load test for a single target or a pair
  always_comb begin
    pp_defer = ld_pend[pp_idx];
    if (pp_dbl && (pp_idx != LAST) && ld_pend[pp_idx + IDXW'(1)]) pp_defer = 1'b1;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_lane
    logic up_w, up_p, hit_w, hit_p, hit_d;
    if (i == 0) begin : g_base
      assign up_w = 1'b0;
      assign up_p = 1'b0;
    end else begin : g_upper
      assign up_w = wr_dbl && (wr_idx == IDXW'(i - 1));
      assign up_p = pp_dbl && (pp_idx == IDXW'(i - 1));
    end
    assign hit_w = wr_vld && ((wr_idx == IDXW'(i)) || up_w);
    assign hit_p = pp_vld && ((pp_idx == IDXW'(i)) || up_p);
    assign hit_d = ld_done_vld && (ld_done_idx == IDXW'(i));

    lat_sb_lane #(.CW(CW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_w),
      .wr_cyc   (wr_cyc),
      .pp_hit   (hit_p),
      .pp_defer (pp_defer),
      .pp_cyc   (pp_cyc),
      .done_hit (hit_d),
      .issue    (issue),
      .busy     (busy_all[i]),
      .lat      (lat_all[i])
    );
  end

  lat_sb_stall_max #(.NREGS(NREGS), .CW(CW), .NSRC(NSRC), .IDXW(IDXW)) u_stall (
    .busy_all (busy_all),
    .src_vld  (src_vld),
    .src_idx  (src_idx),
    .src_dbl  (src_dbl),
    .stall    (stall)
  );

  // load request, one clock after the load-tagged write
  logic            req_vld_q, req_vld_d, req_en;
  logic [IDXW-1:0] req_idx_q;
  reg_cls_e        req_cls_q;
  logic [CW-1:0]   req_dly_q;

  always_comb begin
    req_vld_d = wr_vld && wr_load;
    req_en    = req_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vld_q <= 1'b0;
      req_idx_q <= '0;
      req_cls_q <= CLS_INT;
      req_dly_q <= '0;
    end else begin
      req_vld_q <= req_vld_d;
      if (req_en) begin
        req_idx_q <= wr_idx;
        req_cls_q <= reg_cls_e'(wr_cls);
        req_dly_q <= wr_cyc;
      end
    end
  end

  assign ld_req_vld   = req_vld_q;
  assign ld_req_idx   = req_idx_q;
  assign ld_req_cls   = req_cls_q;
  assign ld_req_delay = req_dly_q;
endmodule

// File: rtl/lat_sb_checker.sv
module lat_sb_checker #(
  parameter int unsigned NREGS = 64,
  parameter int unsigned CW    = 8,
  parameter int unsigned NSRC  = 3,
  parameter int unsigned IDXW  = $clog2(NREGS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     issue,
  input logic                     wr_vld,
  input logic                     wr_load,
  input logic [IDXW-1:0]          wr_idx,
  input logic                     ld_req_vld,
  input logic [IDXW-1:0]          ld_req_idx,
  input logic [NREGS-1:0][CW-1:0] busy_all,
  input logic [NREGS-1:0][CW-1:0] lat_all,
  input logic [NSRC-1:0]          src_vld,
  input logic [NSRC*IDXW-1:0]     src_idx,
  input logic [CW-1:0]            stall
);
  assert_load_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_load) |=> (ld_req_vld && (ld_req_idx == $past(wr_idx))));

  assert_load_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_load) |=> !ld_req_vld);

  assert_stall_covers_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld[0] |-> (stall >= busy_all[src_idx[IDXW-1:0]]));

  for (genvar i = 0; i < NREGS; i++) begin : g_chk
    assert_pending_no_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (lat_all[i] >= $past(lat_all[i])));

    assert_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (busy_all[i] == (($past(busy_all[i]) == '0) ? '0 : ($past(busy_all[i]) - CW'(1)))));

    assert_issue_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (busy_all[i] != '0)) |=> (busy_all[i] >= ($past(busy_all[i]) - CW'(1))));
  end
endmodule

bind lat_scoreboard lat_sb_checker #(.NREGS(NREGS), .CW(CW), .NSRC(NSRC), .IDXW(IDXW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue      (issue),
  .wr_vld     (wr_vld),
  .wr_load    (wr_load),
  .wr_idx     (wr_idx),
  .ld_req_vld (ld_req_vld),
  .ld_req_idx (ld_req_idx),
  .busy_all   (busy_all),
  .lat_all    (lat_all),
  .src_vld    (src_vld),
  .src_idx    (src_idx),
  .stall      (stall)
);

// File: tb/lat_scoreboard_test.sv
module lat_scoreboard_test;
  timeunit 1ns;
  timeprecision 10ps;

  localparam int NREGS = 64;
  localparam int CW    = 8;
  localparam int NSRC  = 3;
  localparam int IDXW  = 6;

  logic                 clk, rst_n;
  logic                 wr_vld, wr_dbl, wr_load, wr_cls;
  logic [IDXW-1:0]      wr_idx;
  logic [CW-1:0]        wr_cyc;
  logic                 pp_vld, pp_dbl;
  logic [IDXW-1:0]      pp_idx;
  logic [CW-1:0]        pp_cyc;
  logic [NREGS-1:0]     ld_pend;
  logic                 ld_done_vld;
  logic [IDXW-1:0]      ld_done_idx;
  logic                 issue;
  logic [NSRC-1:0]      src_vld, src_dbl;
  logic [NSRC*IDXW-1:0] src_idx;
  logic [CW-1:0]        stall;
  logic                 ld_req_vld, ld_req_cls;
  logic [IDXW-1:0]      ld_req_idx;
  logic [CW-1:0]        ld_req_delay;

  int n_chk  = 0;
  int n_fail = 0;

  lat_scoreboard #(.NREGS(NREGS), .CW(CW), .NSRC(NSRC), .IDXW(IDXW)) uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_ops();
    wr_vld = 0; wr_dbl = 0; wr_load = 0; wr_cls = 0; wr_idx = '0; wr_cyc = '0;
    pp_vld = 0; pp_dbl = 0; pp_idx = '0; pp_cyc = '0;
    ld_done_vld = 0; ld_done_idx = '0; issue = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    clear_ops();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic stall_of(input int a, input bit d, output int v);
    src_vld = 3'b001;
    src_dbl = {2'b00, d};
    src_idx = {12'd0, 6'(a)};
    #0.1;
    v = int'(stall);
  endtask

  task automatic do_wr(input int a, input bit d, input bit ld, input bit c, input int cyc, input bit iss);
    wr_vld = 1; wr_idx = 6'(a); wr_dbl = d; wr_load = ld; wr_cls = c; wr_cyc = 8'(cyc); issue = iss;
    tick();
  endtask

  task automatic do_pp(input int a, input bit d, input int cyc, input bit iss);
    pp_vld = 1; pp_idx = 6'(a); pp_dbl = d; pp_cyc = 8'(cyc); issue = iss;
    tick();
  endtask

  task automatic do_done(input int a, input bit iss);
    ld_done_vld = 1; ld_done_idx = 6'(a); issue = iss;
    tick();
  endtask

  task automatic t_reset();
    int v;
    stall_of(0, 0, v);  chk("R11 stall r0 after reset", v, 0);
    stall_of(63, 1, v); chk("R11 stall r63 after reset", v, 0);
    chk("R11 ld_req_vld after reset", int'(ld_req_vld), 0);
  endtask

  task automatic t_topup();
    int v;
    do_wr(5, 0, 0, 0, 4, 0);
    do_wr(5, 0, 0, 0, 2, 1);
    stall_of(5, 0, v); chk("R1 lower write keeps max", v, 4);
    tick();
    stall_of(5, 0, v); chk("R9 countdown by one", v, 3);
    idle(6);
    stall_of(5, 0, v); chk("R9 holds at zero", v, 0);
    do_wr(5, 0, 0, 0, 8, 1);
    do_wr(5, 0, 0, 0, 3, 1);
    stall_of(5, 0, v); chk("R8 issue keeps larger decremented busy", v, 7);
    issue = 1; tick();
    stall_of(5, 0, v); chk("R8 pending cleared after issue", v, 6);
    idle(10);
  endtask

  task automatic t_unused();
    int v;
    wr_vld = 0; wr_idx = 6'd7; wr_load = 1; wr_cyc = 8'd9; issue = 1;
    tick();
    stall_of(7, 0, v); chk("R2 invalid write no latency", v, 0);
    chk("R2 invalid load write no request", int'(ld_req_vld), 0);
    pp_vld = 0; pp_idx = 6'd7; pp_cyc = 8'd9; issue = 1;
    tick();
    stall_of(7, 0, v); chk("R2 invalid post-processing no effect", v, 0);
    do_wr(7, 0, 0, 0, 5, 1);
    src_vld = '0; src_idx = {12'd0, 6'd7}; #0.1;
    chk("R2 invalid source ignored", int'(stall), 0);
    idle(8);
  endtask

  task automatic t_double();
    int v;
    do_wr(10, 1, 0, 0, 5, 1);
    stall_of(10, 0, v); chk("R3 pair low register", v, 5);
    stall_of(11, 0, v); chk("R3 pair upper register", v, 5);
    stall_of(12, 0, v); chk("R3 pair stops at n+1", v, 0);
    idle(8);
    do_wr(63, 1, 0, 0, 7, 1);
    stall_of(63, 0, v); chk("R3 pair at last index", v, 7);
    stall_of(0, 0, v);  chk("R3 pair at last index no wrap", v, 0);
    stall_of(62, 1, v); chk("R10 pair source reads n+1", v, 7);
    stall_of(63, 1, v); chk("R10 pair source at last index", v, 7);
    idle(10);
  endtask

  task automatic t_load();
    do_wr(20, 0, 1, 1, 3, 0);
    chk("R4 request valid", int'(ld_req_vld), 1);
    chk("R4 request index", int'(ld_req_idx), 20);
    chk("R4 request class", int'(ld_req_cls), 1);
    chk("R4 request delay", int'(ld_req_delay), 3);
    tick();
    chk("R4 request one clock only", int'(ld_req_vld), 0);
    do_wr(21, 0, 0, 0, 6, 0);
    chk("R4 plain write no request", int'(ld_req_vld), 0);
    do_wr(22, 1, 1, 0, 4, 1);
    chk("R4 pair load request index", int'(ld_req_idx), 22);
    chk("R4 pair load request class", int'(ld_req_cls), 0);
    idle(10);
  endtask

  task automatic t_post();
    int v;
    ld_pend = '0;
    do_pp(30, 0, 3, 0);
    do_pp(30, 0, 3, 1);
    stall_of(30, 0, v); chk("R5 additive post-processing", v, 6);
    wr_vld = 1; wr_idx = 6'd32; wr_cyc = 8'd5;
    pp_vld = 1; pp_idx = 6'd32; pp_cyc = 8'd2; issue = 1;
    tick();
    stall_of(32, 0, v); chk("R5 added after max write", v, 7);
    do_pp(33, 0, 200, 0);
    do_pp(33, 0, 200, 1);
    stall_of(33, 0, v); chk("R5 saturating addition", v, 255);
    idle(260);
  endtask

  task automatic t_defer();
    int v;
    ld_pend = '0; ld_pend[31] = 1'b1;
    do_pp(31, 0, 4, 1);
    stall_of(31, 0, v); chk("R5 pending load defers cycles", v, 0);
    ld_pend = '0;
    do_done(31, 1);
    stall_of(31, 0, v); chk("R7 completion folds deferred cycles", v, 4);
    idle(10);
    do_done(31, 1);
    stall_of(31, 0, v); chk("R7 deferred counter cleared", v, 0);
  endtask

  task automatic t_dbl_defer();
    int v;
    ld_pend = '0; ld_pend[41] = 1'b1;
    do_pp(40, 1, 5, 1);
    stall_of(40, 0, v); chk("R6 pending on n+1 defers n", v, 0);
    stall_of(41, 0, v); chk("R6 pending on n+1 defers n+1", v, 0);
    ld_pend = '0;
    do_done(40, 1);
    stall_of(40, 0, v); chk("R6 deferred on n", v, 5);
    stall_of(41, 0, v); chk("R6 n+1 still deferred", v, 0);
    do_done(41, 1);
    stall_of(41, 0, v); chk("R6 deferred on n+1", v, 5);
    stall_of(40, 0, v); chk("R9 n counts down", v, 4);
    idle(8);
    do_pp(63, 1, 3, 1);
    stall_of(63, 0, v); chk("R6 pair at last index direct", v, 3);
    stall_of(0, 0, v);  chk("R6 pair at last index no wrap", v, 0);
    idle(6);
  endtask

  task automatic t_max();
    do_wr(1, 0, 0, 0, 3, 1);
    do_wr(2, 0, 0, 0, 9, 1);
    do_wr(3, 0, 0, 0, 5, 1);
    src_vld = 3'b111; src_dbl = '0; src_idx = {6'd3, 6'd2, 6'd1}; #0.1;
    chk("R10 max over three sources", int'(stall), 8);
    src_vld = 3'b011; src_idx = {6'd2, 6'd1, 6'd3}; #0.1;
    chk("R10 max ignores invalid slot", int'(stall), 5);
    src_vld = 3'b001; src_dbl = 3'b001; src_idx = {6'd0, 6'd0, 6'd1}; #0.1;
    chk("R10 pair source takes upper max", int'(stall), 8);
    src_vld = '0; src_dbl = '0;
    idle(12);
  endtask

  initial begin
    rst_n = 0;
    clear_ops();
    ld_pend = '0; src_vld = '0; src_dbl = '0; src_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_topup();
    t_unused();
    t_double();
    t_load();
    t_post();
    t_defer();
    t_dbl_defer();
    t_max();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule